// File: doc/BRIEF.md
# Latching Drive Fault Supervisor

This block guards the power stage of a motor drive. Each clock it looks at the two measured phase currents, the two rotor-frame currents (direct and quadrature axis) and a set of saturation flags from the current controllers. If a current's magnitude goes beyond its limit, or an enabled saturation flag is raised, it sets a sticky fault. That fault drives a block output that shuts down the inverter gates, and a numeric code names the source.

The fault holds until a clear request is given. A clear only releases the block output if no fault condition is present in that cycle. Otherwise the fault is loaded again with the source that is active at that moment. A per-flag enable vector chooses, for each controller saturation flag, whether that flag trips the block or is ignored. A user-interface processor reads the code to report the cause.

Top module: `drive_fault_guard`

## Requirements
- R1: After reset `block_o` is 0 and `err_code_o` is 0. Code 0 means "no fault" and is the code seen whenever `block_o` is 0.
- R2: A phase current (`iu_i`, `iv_i`, signed) whose magnitude is strictly above `PH_LIMIT` (default 6000) sets the fault. The code is 1 for `iu_i` and 2 for `iv_i`. A magnitude equal to the limit does not trip.
- R3: A rotor-frame current (`id_i`, `iq_i`, signed) whose magnitude is strictly above `DQ_LIMIT` (default 20000) sets the fault. The code is 3 for `id_i` and 4 for `iq_i`. A magnitude equal to the limit does not trip.
- R4: Saturation flag k (`sat_i[k]`) trips with code 5+k only while `sat_trip_en_i[k]` is 1. When that enable bit is 0, the flag leaves `block_o` at 0 and `err_code_o` at 0.
- R5: When several sources trip in the same cycle, the lowest code among them is latched.
- R6: Once set, the fault stays set and its code is unchanged while `clr_i` is low. This holds even after the condition goes away or other sources trip later.
- R7: A clear (`clr_i` high) in a cycle with no fault condition returns `block_o` and `err_code_o` to 0 at that clock edge.
- R8: A clear in a cycle where a fault condition is present keeps `block_o` at 1. The code becomes that of the highest-priority source active in that cycle.
- R9: The block output and the code are both registered. They change at the first clock edge at which the condition is present, with no further delay.
- R10: The most negative input value (-2^(W-1)) counts as an over-limit magnitude and trips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iu_i | input | PH_W | Phase U current, signed |
| iv_i | input | PH_W | Phase V current, signed |
| id_i | input | DQ_W | Direct-axis current, signed |
| iq_i | input | DQ_W | Quadrature-axis current, signed |
| sat_i | input | NSAT | Controller saturation flags |
| sat_trip_en_i | input | NSAT | Per-flag trip enable (1 trips, 0 ignores) |
| clr_i | input | 1 | Fault clear request |
| block_o | output | 1 | Power-stage block, 1 disables the inverter |
| err_code_o | output | CODE_W | Latched fault source code, 0 when no fault |

## Verification
The hardest case to reach is a clear that arrives while a fault condition is still active, particularly when the active source differs from the latched one. The bench first latches a quadrature-current fault. It then keeps that current over its limit and also drives the U phase above its limit, and pulses the clear. The expected result is that the block output stays high and the code moves to the U-phase value. The bench also presents exactly-at-limit values and the most negative input values, which tests both sides of the magnitude comparison.

// File: rtl/drive_fault_guard.sv
module drive_fault_guard #(
  parameter int PH_W     = 14,
  parameter int DQ_W     = 16,
  parameter int NSAT     = 4,
  parameter int PH_LIMIT = 6000,
  parameter int DQ_LIMIT = 20000,
  localparam int CODE_W  = $clog2(NSAT + 5)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic signed [PH_W-1:0] iu_i,
  input  logic signed [PH_W-1:0] iv_i,
  input  logic signed [DQ_W-1:0] id_i,
  input  logic signed [DQ_W-1:0] iq_i,
  input  logic [NSAT-1:0]        sat_i,
  input  logic [NSAT-1:0]        sat_trip_en_i,
  input  logic                   clr_i,
  output logic                   block_o,
  output logic [CODE_W-1:0]      err_code_o
);

  localparam int NSRC = NSAT + 4;
  localparam logic signed [PH_W:0] PH_HI = signed'((PH_W+1)'(PH_LIMIT));
  localparam logic signed [PH_W:0] PH_LO = -PH_HI;
  localparam logic signed [DQ_W:0] DQ_HI = signed'((DQ_W+1)'(DQ_LIMIT));
  localparam logic signed [DQ_W:0] DQ_LO = -DQ_HI;

  // one extra bit keeps the most negative sample representable after negation
  logic signed [PH_W:0] iu_x, iv_x;
  logic signed [DQ_W:0] id_x, iq_x;
  assign iu_x = PH_W'(1)'(0) + {iu_i[PH_W-1], iu_i};
  assign iv_x = {iv_i[PH_W-1], iv_i};
  assign id_x = {id_i[DQ_W-1], id_i};
  assign iq_x = {iq_i[DQ_W-1], iq_i};

  logic [NSRC-1:0] src;
  assign src[0] = (iu_x > PH_HI) || (iu_x < PH_LO);
  assign src[1] = (iv_x > PH_HI) || (iv_x < PH_LO);
  assign src[2] = (id_x > DQ_HI) || (id_x < DQ_LO);
  assign src[3] = (iq_x > DQ_HI) || (iq_x < DQ_LO);
  assign src[NSRC-1:4] = sat_i & sat_trip_en_i;

  logic hot;
  logic [CODE_W-1:0] enc;
  assign hot = |src;

  always_comb begin
    enc = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (src[i]) enc = CODE_W'(i + 1);
  end

  logic fault_q;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      code_q  <= '0;
    end else if (clr_i) begin
      fault_q <= hot;
      code_q  <= enc;
    end else if (!fault_q && hot) begin
      fault_q <= 1'b1;
      code_q  <= enc;
    end
  end

  assign block_o    = fault_q;
  assign err_code_o = code_q;

endmodule

module drive_fault_guard_chk #(
  parameter int PH_W     = 14,
  parameter int DQ_W     = 16,
  parameter int NSAT     = 4,
  parameter int PH_LIMIT = 6000,
  parameter int DQ_LIMIT = 20000,
  parameter int CODE_W   = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic signed [PH_W-1:0] iu_i,
  input logic [NSAT-1:0]        sat_i,
  input logic [NSAT-1:0]        sat_trip_en_i,
  input logic                   clr_i,
  input logic                   block_o,
  input logic [CODE_W-1:0]      err_code_o
);

  logic signed [31:0] iu_w;
  logic iu_over;
  assign iu_w    = 32'(iu_i);
  assign iu_over = (iu_w > PH_LIMIT) || (iu_w < -PH_LIMIT);

  assert_idle_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !block_o |-> err_code_o == '0);

  assert_code_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    block_o |-> (err_code_o != '0) && (32'(err_code_o) <= NSAT + 4));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (block_o && !clr_i) |=> block_o && $stable(err_code_o));

  assert_u_trip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (iu_over && !block_o) |=> block_o && err_code_o == CODE_W'(1));

  assert_hot_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && iu_over) |=> block_o && err_code_o == CODE_W'(1));

  assert_masked_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && ((sat_i & sat_trip_en_i) == '0) && sat_i != '0 && !iu_over)
      |=> (!block_o || err_code_o < CODE_W'(5)));

endmodule

bind drive_fault_guard drive_fault_guard_chk #(
  .PH_W(PH_W), .DQ_W(DQ_W), .NSAT(NSAT),
  .PH_LIMIT(PH_LIMIT), .DQ_LIMIT(DQ_LIMIT), .CODE_W(CODE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .iu_i(iu_i), .sat_i(sat_i),
  .sat_trip_en_i(sat_trip_en_i), .clr_i(clr_i),
  .block_o(block_o), .err_code_o(err_code_o)
);

// File: tb/tb_drive_fault_guard.sv
module tb_drive_fault_guard;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [13:0] iu = '0, iv = '0;
  logic signed [15:0] id = '0, iq = '0;
  logic [3:0] sat = '0, en = '0;
  logic clr = 1'b0;
  logic block;
  logic [3:0] code;

  int n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  drive_fault_guard dut (
    .clk(clk), .rst_n(rst_n), .iu_i(iu), .iv_i(iv), .id_i(id), .iq_i(iq),
    .sat_i(sat), .sat_trip_en_i(en), .clr_i(clr),
    .block_o(block), .err_code_o(code)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic eb, input int ec);
    n_run++;
    if (block !== eb || int'(code) != ec) begin
      n_fail++;
      $display("FAIL %s: block=%0b code=%0d expected block=%0b code=%0d",
               req, block, code, eb, ec);
    end
  endtask

  task automatic quiet();
    iu = '0; iv = '0; id = '0; iq = '0; sat = '0; en = '0;
  endtask

  task automatic do_clear();
    quiet(); clr = 1'b1; step(); clr = 1'b0;
    chk("R7", 1'b0, 0);
  endtask

  task automatic t_reset();
    chk("R1", 1'b0, 0);
    step();
    chk("R1", 1'b0, 0);
  endtask

  task automatic t_phase();
    iu = 14'sd6000; step(); chk("R2", 1'b0, 0);
    iu = -14'sd6000; step(); chk("R2", 1'b0, 0);
    iu = 14'sd6001; chk("R9", 1'b0, 0);
    step(); chk("R9", 1'b1, 1);
    do_clear();
    iv = -14'sd6001; step(); chk("R2", 1'b1, 2);
    do_clear();
    iu = -14'sd8192; step(); chk("R10", 1'b1, 1);
    do_clear();
  endtask

  task automatic t_dq();
    id = 16'sd20000; iq = -16'sd20000; step(); chk("R3", 1'b0, 0);
    id = 16'sd20001; iq = '0; step(); chk("R3", 1'b1, 3);
    do_clear();
    iq = -16'sd32768; step(); chk("R10", 1'b1, 4);
    do_clear();
  endtask

  task automatic t_sat();
    sat = 4'b1111; en = 4'b0000; step(); step(); chk("R4", 1'b0, 0);
    en = 4'b0001; sat = 4'b0001; step(); chk("R4", 1'b1, 5);
    do_clear();
    sat = 4'b1010; en = 4'b1000; step(); chk("R4", 1'b1, 8);
    do_clear();
  endtask

  task automatic t_prio();
    iq = 16'sd25000; sat = 4'b0001; en = 4'b0001; iv = 14'sd7000;
    step(); chk("R5", 1'b1, 2);
    do_clear();
  endtask

  task automatic t_sticky();
    iq = 16'sd21000; step(); chk("R6", 1'b1, 4);
    iq = '0; step(); step(); step(); chk("R6", 1'b1, 4);
    iu = 14'sd7000; step(); chk("R6", 1'b1, 4);
    iu = '0;
  endtask

  task automatic t_hot_clear();
    iq = 16'sd21000; clr = 1'b1; step(); clr = 1'b0;
    chk("R8", 1'b1, 4);
    iu = -14'sd7000; clr = 1'b1; step(); clr = 1'b0;
    chk("R8", 1'b1, 1);
    do_clear();
  endtask

  initial begin
    fork
      begin
        #(CLK_P * 3); rst_n = 1'b1; #1;
        t_reset();
        t_phase();
        t_dq();
        t_sat();
        t_prio();
        t_sticky();
        t_hot_clear();
      end
      begin
        #(CLK_P * 5000);
        n_run++; n_fail++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule